// File: doc/BRIEF.md
# Internal ROM Read-Protection Gate

This block sits between the bus controller and an on-chip ROM array and decides, for each ROM read, whether the caller gets the true array word or a fixed substitute word. The decision does not depend on who issued the read. It depends on a lock bit from a configuration register and on where the instruction prefetch counter points at the moment of the read.

When protection is active and the prefetch counter lies outside the internal ROM range, a read returns the constant 0xF0FD and raises a one-cycle denial flag. A window of addresses that holds the interrupt vectors and configuration bytes is always readable.

The decision uses the prefetch address, not the execution address. The prefetch counter can run up to eight bytes ahead of the instruction being executed. As a result, reads made while executing the last few bytes of internal ROM may be refused once prefetch has crossed the ROM's upper limit.

Top module: `rom_read_guard`

## Requirements
- R1: After reset, and until the first read strobe, `readData` is 0 and `readDenied` is 0.
- R2: When `lockBit` is 1 at the strobe, the read returns `romWord` unchanged with `readDenied` 0, whatever the value of `fetchAddr`.
- R3: When `lockBit` is 0 and `fetchAddr` lies within ROM_BASE..ROM_LAST inclusive, the read returns `romWord` with `readDenied` 0.
- R4: When `lockBit` is 0, `fetchAddr` is outside ROM_BASE..ROM_LAST, and `readAddr` is outside the exempt window, `readData` becomes 0xF0FD and `readDenied` is 1.
- R5: A `readAddr` inside EXEMPT_LO..EXEMPT_HI inclusive always returns `romWord` with `readDenied` 0. The addresses just outside the window follow R4.
- R6: The result of a strobe appears on the outputs at the next rising clock edge. Back-to-back strobes give one result per cycle, in order.
- R7: In a cycle with no strobe, the next edge holds `readData` unchanged and drives `readDenied` to 0, so a denial lasts one clock.
- R8: For the range test, `fetchAddr` equal to ROM_LAST counts as internal, while ROM_LAST+1 and ROM_BASE-1 count as external.
- R9: `lockBit`, `fetchAddr`, `readAddr` and `romWord` are used only at the strobe edge. Changes to them between strobes do not alter the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lockBit | input | 1 | Configuration lock bit: 0 enables protection, 1 disables it |
| readStrobe | input | 1 | High for one cycle per ROM read |
| readAddr | input | ADDR_W | Address of the requested ROM word |
| fetchAddr | input | ADDR_W | Current prefetch (slave) program counter |
| romWord | input | DATA_W | Word delivered by the ROM array for readAddr |
| readData | output | DATA_W | Registered read result |
| readDenied | output | 1 | High for one cycle when the read was substituted |

## Verification
Two outcomes can meet in the same cycle: the substitution of a blocked read and the pass-through of an exempt or unlocked read. The bench provokes this with back-to-back strobes that alternate between a denied address and an exempt address, and between lock values, with no idle cycle in between. The scoreboard then expects the flag to fall and the true word to appear on the very next edge. It also toggles the lock bit, the ROM word and the fetch address during idle cycles, and expects the last result to stay unchanged.

// File: rtl/rom_guard_pkg.sv
package rom_guard_pkg;
  typedef struct packed {
    logic capture;     // a read is being accepted this cycle
    logic substitute;  // the accepted read must be replaced
  } guardStrobes_t;
endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import rom_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 16'h2000,
  parameter logic [ADDR_W-1:0] ROM_LAST  = 16'h3FFF,
  parameter logic [ADDR_W-1:0] EXEMPT_LO = 16'h2000,
  parameter logic [ADDR_W-1:0] EXEMPT_HI = 16'h207F
) (
  input  logic              lockBit,
  input  logic              readStrobe,
  input  logic [ADDR_W-1:0] readAddr,
  input  logic [ADDR_W-1:0] fetchAddr,
  output guardStrobes_t     strobes
);
  logic fetchInternal;
  logic addrExempt;
  logic protectOn;

  always_comb begin
    fetchInternal = (fetchAddr >= ROM_BASE) && (fetchAddr <= ROM_LAST);
    addrExempt    = (readAddr >= EXEMPT_LO) && (readAddr <= EXEMPT_HI);
    protectOn     = ~lockBit;
    strobes.capture    = readStrobe;
    strobes.substitute = readStrobe && protectOn && !fetchInternal && !addrExempt;
  end
endmodule

// File: rtl/guard_datapath.sv
module guard_datapath
  import rom_guard_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] DENY_WORD = 16'hF0FD
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobes_t     strobes,
  input  logic [DATA_W-1:0] romWord,
  output logic [DATA_W-1:0] readData,
  output logic              readDenied
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readData   <= '0;
      readDenied <= 1'b0;
    end else begin
      readDenied <= strobes.substitute;
      if (strobes.capture)
        readData <= strobes.substitute ? DENY_WORD : romWord;
    end
  end
endmodule

// File: rtl/rom_read_guard.sv
module rom_read_guard
  import rom_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 16'h2000,
  parameter logic [ADDR_W-1:0] ROM_LAST  = 16'h3FFF,
  parameter logic [ADDR_W-1:0] EXEMPT_LO = 16'h2000,
  parameter logic [ADDR_W-1:0] EXEMPT_HI = 16'h207F,
  parameter logic [DATA_W-1:0] DENY_WORD = 16'hF0FD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lockBit,
  input  logic              readStrobe,
  input  logic [ADDR_W-1:0] readAddr,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [DATA_W-1:0] romWord,
  output logic [DATA_W-1:0] readData,
  output logic              readDenied
);
  guardStrobes_t strobes;

  guard_ctrl #(
    .ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE), .ROM_LAST(ROM_LAST),
    .EXEMPT_LO(EXEMPT_LO), .EXEMPT_HI(EXEMPT_HI)
  ) i_ctrl (
    .lockBit(lockBit), .readStrobe(readStrobe), .readAddr(readAddr),
    .fetchAddr(fetchAddr), .strobes(strobes)
  );

  guard_datapath #(.DATA_W(DATA_W), .DENY_WORD(DENY_WORD)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .romWord(romWord),
    .readData(readData), .readDenied(readDenied)
  );
endmodule

// File: rtl/guard_checker.sv
module guard_checker #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 16'h2000,
  parameter logic [ADDR_W-1:0] ROM_LAST  = 16'h3FFF,
  parameter logic [ADDR_W-1:0] EXEMPT_LO = 16'h2000,
  parameter logic [ADDR_W-1:0] EXEMPT_HI = 16'h207F,
  parameter logic [DATA_W-1:0] DENY_WORD = 16'hF0FD
) (
  input logic              clk,
  input logic              rstN,
  input logic              lockBit,
  input logic              readStrobe,
  input logic [ADDR_W-1:0] readAddr,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [DATA_W-1:0] romWord,
  input logic [DATA_W-1:0] readData,
  input logic              readDenied
);
  // R4
  denied_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    readDenied |-> readData == DENY_WORD);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readStrobe |=> !readDenied && $stable(readData));

  // R2
  unlocked_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe && lockBit |=> !readDenied && readData == $past(romWord));

  // R5
  exempt_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe && readAddr >= EXEMPT_LO && readAddr <= EXEMPT_HI
      |=> !readDenied && readData == $past(romWord));

  // R3
  internal_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe && fetchAddr >= ROM_BASE && fetchAddr <= ROM_LAST |=> !readDenied);
endmodule

bind rom_read_guard guard_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_BASE(ROM_BASE), .ROM_LAST(ROM_LAST),
  .EXEMPT_LO(EXEMPT_LO), .EXEMPT_HI(EXEMPT_HI), .DENY_WORD(DENY_WORD)
) i_guard_checker (.*);

// File: tb/test_rom_read_guard.sv
module test_rom_read_guard;
  localparam logic [15:0] BASE = 16'h2000, LAST = 16'h3FFF;
  localparam logic [15:0] EXLO = 16'h2000, EXHI = 16'h207F;

  logic clk = 0, rstN = 0, lockBit = 1, readStrobe = 0;
  logic [15:0] readAddr = 0, fetchAddr = 0, romWord = 0;
  logic [15:0] readData;
  logic readDenied;

  rom_read_guard i_rom_read_guard (.*);

  always #10 clk = ~clk;

  typedef struct { logic [15:0] data; logic denied; string tag; } expItem_t;
  expItem_t expQ[$];
  int checks = 0, fails = 0;
  logic [15:0] lastData = 0;
  bit done = 0;

  function automatic expItem_t model(logic lk, logic [15:0] ra, logic [15:0] fa,
                                     logic [15:0] w, string tag);
    expItem_t e;
    bit ext = (fa < BASE) || (fa > LAST);
    bit exm = (ra >= EXLO) && (ra <= EXHI);
    e.tag = tag;
    if (!lk && ext && !exm) begin e.data = 16'hF0FD; e.denied = 1; end
    else begin e.data = w; e.denied = 0; end
    return e;
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] ad, logic ae,
                       logic [15:0] ed, logic ee);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: data=%h denied=%b expected data=%h denied=%b",
               tag, ad, ae, ed, ee);
    end
  endtask

  task automatic doRead(logic lk, logic [15:0] ra, logic [15:0] fa,
                        logic [15:0] w, string tag);
    @(negedge clk);
    lockBit = lk; readAddr = ra; fetchAddr = fa; romWord = w; readStrobe = 1;
    expQ.push_back(model(lk, ra, fa, w, tag));
  endtask

  // idle cycles that disturb every sampled input (R9)
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      readStrobe = 0;
      lockBit = ~lockBit; romWord = romWord ^ 16'h5A5A;
      fetchAddr = fetchAddr + 16'h1111; readAddr = readAddr + 16'h0F0F;
    end
  endtask

  // monitor: compare one edge after each strobe (R6)
  always @(posedge clk) begin
    logic strobeSeen;
    strobeSeen = readStrobe;
    #5;
    if (rstN && !done) begin
      if (strobeSeen) begin
        if (expQ.size() == 0) check(0, "R6 unexpected result", readData, readDenied, 0, 0);
        else begin
          expItem_t e;
          e = expQ.pop_front();
          check(readData == e.data && readDenied == e.denied, e.tag,
                readData, readDenied, e.data, e.denied);
        end
      end else begin
        check(readData == lastData && !readDenied, "R7 R9 hold",
              readData, readDenied, lastData, 0);
      end
      lastData = readData;
    end
  end

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: data=%h denied=%b expected data=---- denied=-", readData, readDenied);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(readData == 0 && readDenied == 0, "R1 reset", readData, readDenied, 0, 0);
    rstN = 1;
    @(negedge clk);
    check(readData == 0 && readDenied == 0, "R1 after release", readData, readDenied, 0, 0);

    doRead(1, 16'h3000, 16'h8000, 16'h1234, "R2 unlocked ext fetch");
    idle(2);
    doRead(0, 16'h3000, 16'h2400, 16'hABCD, "R3 internal fetch");
    doRead(0, 16'h3000, 16'h8000, 16'h4444, "R4 blocked");
    doRead(0, EXLO,     16'h8000, 16'h0101, "R5 exempt low");
    doRead(0, EXHI,     16'h8000, 16'h0202, "R5 exempt high");
    doRead(0, EXHI + 1, 16'h8000, 16'h0303, "R5 R4 above window");
    idle(3);
    doRead(0, 16'h3FF8, LAST,     16'h7777, "R8 fetch at last");
    doRead(0, 16'h3FF8, LAST + 1, 16'h8888, "R8 fetch past last");
    doRead(0, 16'h3FF8, BASE - 1, 16'h9999, "R8 fetch below base");
    doRead(1, 16'h3FF8, BASE - 1, 16'hAAAA, "R6 R2 back to back");
    doRead(0, 16'h2500, 16'hFFF0, 16'hBBBB, "R6 R4 back to back");
    doRead(0, 16'h2010, 16'hFFF0, 16'hCCCC, "R6 R5 back to back");
    idle(4);
    doRead(0, 16'h3100, 16'h0000, 16'hDDDD, "R4 zero fetch");
    idle(3);
    check(expQ.size() == 0, "R6 all results seen", 16'(expQ.size()), 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule